// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with Fast-Line Split

This block collects a set of level-sensitive interrupt request lines and presents them to a processor on two outputs. One designated source line goes only to a fast-interrupt output. Every other line is combined onto the normal interrupt output. Nothing is latched. A source counts as pending for exactly as long as its input is high and its enable bit is set.

Software controls the block through a small word-addressed register window. One register holds the per-line enables and can be read and written. A second register is read-only and shows which sources are active and enabled at the moment of the read. The enable register comes out of reset with a fixed mixed pattern, so some lines start masked. Both processor outputs are combinational functions of the source levels and the stored enables.

Top module: `lirq_split`

## Requirements
- R1: After reset the enable register (word offset 0x48) reads as 0xFFFEF7FF. Bits 11 and 16 are clear and all other bits are set.
- R2: A write to offset 0x48 stores all 32 data bits into the enable register. A later read of 0x48 returns exactly those bits.
- R3: A read of offset 0x44 returns the bitwise AND of the source levels and the enable register, both sampled at the clock edge that accepts the read.
- R4: `fiq_o` is high exactly when source line 8 is high and enable bit 8 is set.
- R5: `irq_o` is high exactly when at least one source line other than line 8 is high with its enable bit set.
- R6: Line 8 never affects `irq_o`, and no line other than line 8 affects `fiq_o`.
- R7: A read of any offset other than 0x44 and 0x48 returns zero, including unaligned offsets such as 0x46. A write to any such offset leaves the enable register unchanged.
- R8: No source is latched. When a source line falls, its status bit and its output contribution drop without any software action.
- R9: Read data appears on `bus_rdata` in the cycle after the clock edge that accepts `bus_rd`. It is zero in any cycle that follows an edge with no read accepted.
- R10: A new enable value written at a clock edge governs `irq_o` and `fiq_o` from that edge onward. Before that edge the old value still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | 32 | Interrupt source levels, one bit per line |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_rd | input | 1 | Read strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, zero when no read was accepted |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
The bench builds the block with its default parameters: 32 source lines, fast line 8, an 8-bit offset bus, and the 0xFFFEF7FF reset enable. With these values the two lines masked at reset (11 and 16) can be driven high, which shows that a masked level reaches neither output nor the status register. The fast line sits inside the first enabled byte, so the split between the two outputs can be seen without any software setup. The 8-bit offset space also lets the bench reach unaligned and unmapped offsets, next to the two live registers.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

  // Register selected by a bus offset
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_EN   = 2'd2
  } lirq_sel_e;

endpackage

// File: rtl/lirq_route.sv
module lirq_route #(
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned FAST_LINE = 8
) (
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] pend,
  output logic               irq_o,
  output logic               fiq_o
);

  function automatic logic [NUM_SRC-1:0] gate_lines(input logic [NUM_SRC-1:0] lvl,
                                                   input logic [NUM_SRC-1:0] en);
    return lvl & en;
  endfunction

  logic [NUM_SRC-1:0] fast_bits;
  logic [NUM_SRC-1:0] slow_bits;

  assign pend = gate_lines(src_lvl, en_q);

  // Each line goes to exactly one of the two outputs
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_steer
    if (i == FAST_LINE) begin : g_fast
      assign fast_bits[i] = pend[i];
      assign slow_bits[i] = 1'b0;
    end else begin : g_slow
      assign fast_bits[i] = 1'b0;
      assign slow_bits[i] = pend[i];
    end
  end

  assign irq_o = |slow_bits;
  assign fiq_o = |fast_bits;

endmodule

// File: rtl/lirq_regs.sv
module lirq_regs
  import lirq_pkg::*;
#(
  parameter int unsigned          NUM_SRC  = 32,
  parameter int unsigned          ADDR_W   = 8,
  parameter int unsigned          STAT_OFS = 'h44,
  parameter int unsigned          EN_OFS   = 'h48,
  parameter logic [NUM_SRC-1:0]   EN_RESET = 32'hFFFE_F7FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [NUM_SRC-1:0] bus_wdata,
  input  logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] bus_rdata
);

  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_OFS);

  function automatic lirq_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a == STAT_A)    return SEL_STAT;
    else if (a == EN_A) return SEL_EN;
    else                return SEL_NONE;
  endfunction

  lirq_sel_e          sel;
  logic               en_wr;
  logic [NUM_SRC-1:0] rd_mux;

  assign sel   = decode(bus_addr);
  assign en_wr = bus_wr && (sel == SEL_EN);

  always_comb begin
    unique case (sel)
      SEL_STAT: rd_mux = pend;
      SEL_EN:   rd_mux = en_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= EN_RESET;
    end else if (en_wr) begin
      en_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= bus_rd ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/lirq_split.sv
module lirq_split #(
  parameter int unsigned        NUM_SRC   = 32,
  parameter int unsigned        FAST_LINE = 8,
  parameter int unsigned        ADDR_W    = 8,
  parameter int unsigned        STAT_OFS  = 'h44,
  parameter int unsigned        EN_OFS    = 'h48,
  parameter logic [NUM_SRC-1:0] EN_RESET  = 32'hFFFE_F7FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic               irq_o,
  output logic               fiq_o
);

  // Named internal state, brought out for the checker
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] pend_w;

  lirq_regs #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .STAT_OFS(STAT_OFS),
    .EN_OFS  (EN_OFS),
    .EN_RESET(EN_RESET)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .pend     (pend_w),
    .en_q     (en_q),
    .bus_rdata(bus_rdata)
  );

  lirq_route #(
    .NUM_SRC  (NUM_SRC),
    .FAST_LINE(FAST_LINE)
  ) u_route (
    .src_lvl(src_lvl),
    .en_q   (en_q),
    .pend   (pend_w),
    .irq_o  (irq_o),
    .fiq_o  (fiq_o)
  );

endmodule

// File: rtl/lirq_split_sva.sv
module lirq_split_sva #(
  parameter int unsigned        NUM_SRC   = 32,
  parameter int unsigned        FAST_LINE = 8,
  parameter int unsigned        ADDR_W    = 8,
  parameter int unsigned        STAT_OFS  = 'h44,
  parameter int unsigned        EN_OFS    = 'h48,
  parameter logic [NUM_SRC-1:0] EN_RESET  = 32'hFFFE_F7FF
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_lvl,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [NUM_SRC-1:0] bus_wdata,
  input logic [NUM_SRC-1:0] bus_rdata,
  input logic               irq_o,
  input logic               fiq_o,
  input logic [NUM_SRC-1:0] en_q
);

  localparam logic [NUM_SRC-1:0] FAST_M = NUM_SRC'(1) << FAST_LINE;
  localparam logic [ADDR_W-1:0]  STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0]  EN_A   = ADDR_W'(EN_OFS);

  p_reset_val_r1: assert property (@(posedge clk)
    !rst_n |=> en_q == EN_RESET);

  p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == EN_A) |=> en_q == $past(bus_wdata));

  p_en_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == EN_A) |=> bus_rdata == $past(en_q));

  p_status_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == STAT_A) |=> bus_rdata == $past(src_lvl & en_q));

  p_fast_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o == (src_lvl[FAST_LINE] & en_q[FAST_LINE]));

  p_norm_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|(src_lvl & en_q & ~FAST_M)));

  p_other_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == EN_A) |=> $stable(en_q));

  p_other_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != EN_A && bus_addr != STAT_A) |=> bus_rdata == '0);

  p_idle_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0);

endmodule

bind lirq_split lirq_split_sva #(
  .NUM_SRC  (NUM_SRC),
  .FAST_LINE(FAST_LINE),
  .ADDR_W   (ADDR_W),
  .STAT_OFS (STAT_OFS),
  .EN_OFS   (EN_OFS),
  .EN_RESET (EN_RESET)
) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_lvl  (src_lvl),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .en_q     (en_q)
);

// File: tb/lirq_split_bench.sv
module lirq_split_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lvl = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        fiq_o;

  int total = 0;
  int bad   = 0;
  bit chk_en = 1'b0;
  bit done   = 1'b0;

  // Reference model state
  logic [31:0] m_en = 32'hFFFE_F7FF;
  logic [31:0] m_rdata = '0;
  string       m_rtag = "R9";

  always #10 clk = ~clk;

  lirq_split u_lirq_split (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Model: advances at each rising edge from the inputs held there
  always @(posedge clk) begin
    if (!rst_n) begin
      m_en    = 32'hFFFE_F7FF;
      m_rdata = '0;
      m_rtag  = "R1";
    end else begin
      if (!bus_rd) begin
        m_rdata = '0;
        m_rtag  = "R9";
      end else if (bus_addr == 8'h48) begin
        m_rdata = m_en;
        m_rtag  = "R2";
      end else if (bus_addr == 8'h44) begin
        m_rdata = src_lvl & m_en;
        m_rtag  = "R3";
      end else begin
        m_rdata = '0;
        m_rtag  = "R7";
      end
      if (bus_wr && bus_addr == 8'h48) m_en = bus_wdata;
    end
  end

  // Per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (chk_en) begin
      int n_slow;
      n_slow = 0;
      for (int i = 0; i < 32; i++)
        if (i != 8 && src_lvl[i] && m_en[i]) n_slow++;
      check(m_rtag, bus_rdata, m_rdata);
      check("R5", {31'd0, irq_o}, {31'd0, n_slow > 0});
      check("R4", {31'd0, fiq_o}, {31'd0, src_lvl[8] && m_en[8]});
    end
  end

  // One bus access: driven after a falling edge, strobes dropped after the edge
  task automatic access(input bit w, input bit r, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #2;
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic set_lvl(input logic [31:0] v);
    @(negedge clk); #2;
    src_lvl = v;
    @(negedge clk); #1;
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog: got=timeout expected=completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk); #1;
    check("R9", bus_rdata, 32'h0);
    chk_en = 1'b1;

    // R1: reset enable pattern
    access(0, 1, 8'h48, '0);
    check("R1", bus_rdata, 32'hFFFE_F7FF);

    // R6: line 8 alone drives only the fast output
    set_lvl(32'h0000_0100);
    check("R6", {30'd0, irq_o, fiq_o}, 32'h1);
    // R6: every other enabled line drives only the normal output
    set_lvl(32'hFFFF_FEFF);
    check("R6", {30'd0, irq_o, fiq_o}, 32'h2);
    // masked lines 11 and 16 reach nothing
    set_lvl(32'h0001_0800);
    check("R1", {30'd0, irq_o, fiq_o}, 32'h0);
    access(0, 1, 8'h44, '0);
    check("R3", bus_rdata, 32'h0);

    // R2: full write and readback
    access(1, 0, 8'h48, 32'h0001_0000);
    access(0, 1, 8'h48, '0);
    check("R2", bus_rdata, 32'h0001_0000);
    check("R10", {31'd0, irq_o}, 32'h1);

    // R10: new enable applies only from the write edge
    @(negedge clk); #2;
    bus_wr = 1'b1; bus_addr = 8'h48; bus_wdata = 32'h0;
    #5 check("R10", {31'd0, irq_o}, 32'h1);
    @(posedge clk); #1;
    bus_wr = 1'b0;
    check("R10", {31'd0, irq_o}, 32'h0);
    @(negedge clk); #1;

    // R7: unmapped and unaligned writes and reads
    access(1, 0, 8'h4C, 32'hFFFF_FFFF);
    access(1, 0, 8'h46, 32'hFFFF_FFFF);
    access(0, 1, 8'h48, '0);
    check("R7", bus_rdata, 32'h0);
    access(1, 0, 8'h48, 32'hFFFF_FFFF);
    set_lvl(32'hFFFF_FFFF);
    access(0, 1, 8'h46, '0);
    check("R7", bus_rdata, 32'h0);
    access(0, 1, 8'h00, '0);
    check("R7", bus_rdata, 32'h0);

    // R8: status follows levels without latching
    set_lvl(32'h0000_0104);
    access(0, 1, 8'h44, '0);
    check("R8", bus_rdata, 32'h0000_0104);
    set_lvl(32'h0000_0000);
    check("R8", {30'd0, irq_o, fiq_o}, 32'h0);
    access(0, 1, 8'h44, '0);
    check("R8", bus_rdata, 32'h0);

    // Random traffic compared against the model every cycle
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] a;
      int unsigned pick;
      pick = $urandom_range(0, 5);
      case (pick)
        0, 1: a = 8'h44;
        2, 3: a = 8'h48;
        4:    a = 8'h46;
        default: a = 8'($urandom);
      endcase
      @(negedge clk); #2;
      src_lvl   = $urandom;
      bus_addr  = a;
      bus_wdata = $urandom;
      bus_wr    = ($urandom_range(0, 3) == 0);
      bus_rd    = ($urandom_range(0, 1) == 0);
    end
    @(negedge clk); #2;
    bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    finish_up();
  end

endmodule